// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps wall-clock time and date as packed BCD counters: seconds, minutes, hours, weekday, day of month, month, and a two-byte year (century byte above, year-within-century byte below). A sub-second prescaler counts a 128 Hz tick enable. Each time the prescaler wraps, the seconds counter advances. A carry then ripples through the calendar fields, which track month lengths and leap years.

Software reaches the block through a simple register port with a 16-bit write data bus and a combinational read mux. A carry flag is raised on every seconds increment. Software clears the flag, reads the time fields, and reads again if the flag has come back on, so that it never uses a torn snapshot. A control register starts and stops counting, and a reset bit clears the prescaler and halts the clock. The time fields can only be written while the clock is halted. The interrupt line reflects the carry flag when the carry interrupt is enabled.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset: seconds, minutes and hours are 0x00, weekday 0x06, day 0x01, month 0x01, year 0x2000, the sub-second count is 0, both control registers read 0x00, the clock is stopped and irq is low.
- R2: While running, seconds advance on every 128th tick enable. Seconds and minutes count 0x00..0x59 in BCD, hours count 0x00..0x23, and each field wraps to its floor and carries into the next field.
- R3: When hours wrap, the day advances. Months 0x04, 0x06, 0x09 and 0x11 have 30 days. Month 0x02 has 29 days when the binary value of the BCD year-low byte is divisible by 4, and 28 otherwise. All other months have 31. Day wraps to 0x01 and carries into the month.
- R4: Month wraps 0x12 to 0x01 and carries into the year-low byte. The year-low byte wraps 0x99 to 0x00 and carries into the century byte, which wraps 0x99 to 0x00. Weekday counts 0..6 and advances on the hours wrap, going from 6 back to 0.
- R5: Register addresses: 0 sub-second count (read only), 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year (16 bits, century in [15:8]), 8 control-1, 9 control-2. Byte fields use write data [7:0]. Unmapped addresses read 0.
- R6: Writes to the time fields (addresses 1..7) take effect only while the clock is not running. While it runs, they are ignored.
- R7: Control-2 layout: bit 3 enables the clock and bit 0 starts it. Counting happens only when both are set. Writing bit 1 as 1 clears the prescaler and the start bit; bit 1 reads 0. Bits 6:4 (rate) are stored and read back. Bit 7 (periodic flag) can only be cleared by a write.
- R8: Control-1 bit 7 is the carry flag. It is set on every seconds increment. Writing 0 to bit 7 clears it, writing 1 leaves it unchanged, and a set in the same cycle wins. Bits 4 (carry irq enable) and 3 (alarm irq enable) are stored. Bit 0 (alarm flag) can only be cleared by a write.
- R9: irq is high exactly while the carry flag and control-1 bit 4 are both set.
- R10: Reading address 0 returns the prescaler count, zero-extended, which counts 0..127 on tick enables while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at 128 Hz |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Carry interrupt |

## Verification
The counting function is tried with preset dates chosen so that one second crosses a single field boundary, a BCD digit boundary inside a field, or the whole chain up to a new century. Month ends are tried for 28-, 29-, 30- and 31-day months, on leap and non-leap years, including a year-low byte of 00. This separates a wrong day ceiling from a wrong carry order. Each preset also sets its own weekday, so that a weekday that advances on the wrong event is caught. Directed sequences set the prescaler midway and then use the reset bit, run with only one of the two run bits set, and write fields while running. They also write the carry flag with both 0 and 1, to separate clear-on-zero from store behaviour.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int NFIELD = 8;   // sec, min, hour, wday, day, month, year-lo, year-hi
   localparam int F_SEC  = 0;
   localparam int F_HOUR = 2;
   localparam int F_DAY  = 4;
   localparam int F_MON  = 5;
   localparam int F_YLO  = 6;

   function automatic logic [7:0] bcd_next(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
      return v + 8'd1;
   endfunction

   // binary value mod 4 = (2*tens + units) mod 4
   function automatic logic leap_year(input logic [7:0] y);
      logic [4:0] s;
      s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] ylo);
      case (mon)
         8'h02:                   return leap_year(ylo) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                 return 8'h31;
      endcase
   endfunction

   function automatic logic [7:0] field_floor(input int i);
      return (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
   endfunction

   function automatic logic [7:0] field_ceiling(input int i);
      case (i)
         0, 1:    return 8'h59;
         2:       return 8'h23;
         3:       return 8'h06;
         4:       return 8'h31;
         5:       return 8'h12;
         default: return 8'h99;
      endcase
   endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field import rtc_cal_pkg::*; #(
   parameter logic [7:0] FLOOR = 8'h00,
   parameter logic [7:0] RST   = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic [7:0] ceil_v,
   input  logic       ld,
   input  logic [7:0] ld_val,
   output logic [7:0] q,
   output logic       wrap
);

   logic at_top;
   assign at_top = (q >= ceil_v);
   assign wrap   = inc && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST;
      else if (ld)  q <= ld_val;
      else if (inc) q <= at_top ? FLOOR : bcd_next(q);
   end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         run,
   input  logic         clr,
   output logic [W-1:0] cnt,
   output logic         sec_tick
);

   assign sec_tick = tick && run && !clr && (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (tick && run) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar import rtc_cal_pkg::*; #(
   parameter logic [8*NFIELD-1:0] RST_TIME = 64'h2000_0101_0600_0000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sec_tick,
   input  logic [NFIELD-1:0]       ld,
   input  logic [NFIELD-1:0][7:0]  ld_val,
   output logic [NFIELD-1:0][7:0]  q
);

   logic [NFIELD-1:0]      inc;
   logic [NFIELD-1:0]      wrap;
   logic [NFIELD-1:0][7:0] ceil_v;
   logic                   century_wrap_unused;

   assign century_wrap_unused = wrap[NFIELD-1];

   always_comb begin
      for (int i = 0; i < NFIELD; i++) ceil_v[i] = field_ceiling(i);
      ceil_v[F_DAY] = month_days(q[F_MON], q[F_YLO]);
   end

   // carry chain: weekday and day both step on the hour wrap
   always_comb begin
      inc[0] = sec_tick;
      inc[1] = wrap[0];
      inc[2] = wrap[1];
      inc[3] = wrap[F_HOUR];
      inc[4] = wrap[F_HOUR];
      inc[5] = wrap[F_DAY];
      inc[6] = wrap[F_MON];
      inc[7] = wrap[F_YLO];
   end

   for (genvar i = 0; i < NFIELD; i++) begin : g_fld
      localparam logic [7:0] FL = field_floor(i);
      rtc_bcd_field #(.FLOOR(FL), .RST(RST_TIME[8*i +: 8])) u_fld (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (inc[i]),
         .ceil_v (ceil_v[i]),
         .ld     (ld[i]),
         .ld_val (ld_val[i]),
         .q      (q[i]),
         .wrap   (wrap[i])
      );
   end

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar import rtc_cal_pkg::*; #(
   parameter int                  ADDR_W   = 4,
   parameter int                  PRESC_W  = 7,
   parameter logic [8*NFIELD-1:0] RST_TIME = 64'h2000_0101_0600_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] A_SUB   = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_YEAR  = ADDR_W'(7);
   localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] A_CTRL2 = ADDR_W'(9);
   localparam int                BYTE_FIELDS = NFIELD - 2;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("rtc_bcd_calendar: ADDR_W must be at least 4");
   end
   if (PRESC_W < 2 || PRESC_W > 16) begin : g_bad_presc
      $error("rtc_bcd_calendar: PRESC_W must lie in 2..16");
   end

   // control state
   logic       cf, cie, aie, af;
   logic       pf, en, start;
   logic [2:0] rate;
   logic       run, presc_clr, sec_tick, wr_c1, wr_c2, wr_time;
   logic [PRESC_W-1:0]      presc;
   logic [NFIELD-1:0]       ld;
   logic [NFIELD-1:0][7:0]  ld_val;
   logic [NFIELD-1:0][7:0]  cal_q;
   logic [7:0]              sec_q;

   assign run       = en && start;
   assign wr_c1     = bus_wr && (bus_addr == A_CTRL1);
   assign wr_c2     = bus_wr && (bus_addr == A_CTRL2);
   assign presc_clr = wr_c2 && bus_wdata[1];
   assign wr_time   = bus_wr && !run;
   assign sec_q     = cal_q[F_SEC];

   for (genvar i = 0; i < BYTE_FIELDS; i++) begin : g_ld_byte
      assign ld[i]     = wr_time && (bus_addr == ADDR_W'(i + 1));
      assign ld_val[i] = bus_wdata[7:0];
   end
   assign ld[F_YLO]       = wr_time && (bus_addr == A_YEAR);
   assign ld[NFIELD-1]    = wr_time && (bus_addr == A_YEAR);
   assign ld_val[F_YLO]   = bus_wdata[7:0];
   assign ld_val[NFIELD-1] = bus_wdata[15:8];

   rtc_prescaler #(.W(PRESC_W)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_en),
      .run      (run),
      .clr      (presc_clr),
      .cnt      (presc),
      .sec_tick (sec_tick)
   );

   rtc_calendar #(.RST_TIME(RST_TIME)) u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .ld       (ld),
      .ld_val   (ld_val),
      .q        (cal_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cf  <= 1'b0;
         cie <= 1'b0;
         aie <= 1'b0;
         af  <= 1'b0;
      end else begin
         if (wr_c1) begin
            cie <= bus_wdata[4];
            aie <= bus_wdata[3];
            af  <= af & bus_wdata[0];
         end
         if (sec_tick)   cf <= 1'b1;
         else if (wr_c1) cf <= cf & bus_wdata[7];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pf    <= 1'b0;
         rate  <= 3'd0;
         en    <= 1'b0;
         start <= 1'b0;
      end else if (wr_c2) begin
         pf    <= pf & bus_wdata[7];
         rate  <= bus_wdata[6:4];
         en    <= bus_wdata[3];
         start <= bus_wdata[0] & ~bus_wdata[1];
      end
   end

   assign irq = cf && cie;

   always_comb begin
      bus_rdata = 16'h0000;
      if (bus_addr == A_SUB)
         bus_rdata = 16'(presc);
      else if (bus_addr == ADDR_W'(1))
         bus_rdata = {8'h00, sec_q};
      else if (bus_addr == A_YEAR)
         bus_rdata = {cal_q[NFIELD-1], cal_q[F_YLO]};
      else if (bus_addr == A_CTRL1)
         bus_rdata = {8'h00, cf, 2'b00, cie, aie, 2'b00, af};
      else if (bus_addr == A_CTRL2)
         bus_rdata = {8'h00, pf, rate, en, 1'b0, 1'b0, start};
      else
         for (int i = 1; i < BYTE_FIELDS; i++)
            if (bus_addr == ADDR_W'(i + 1)) bus_rdata = {8'h00, cal_q[i]};
   end

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk #(
   parameter int PRESC_W = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic               sec_tick,
   input logic               presc_clr,
   input logic               bus_wr,
   input logic               cf,
   input logic               cie,
   input logic               irq,
   input logic [7:0]         sec,
   input logic [PRESC_W-1:0] presc
);

   AST_CARRY_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> cf);  // R8

   AST_SECOND_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> (sec != $past(sec)));  // R2

   AST_SECOND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (sec[3:0] <= 4'd9) && (sec <= 8'h59));  // R2

   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !bus_wr) |=> $stable(sec));  // R7

   AST_RESET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      presc_clr |=> (presc == '0) && !run);  // R7

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cf);  // R9

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !cie |-> !irq);  // R9

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk #(.PRESC_W(PRESC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .sec_tick  (sec_tick),
   .presc_clr (presc_clr),
   .bus_wr    (bus_wr),
   .cf        (cf),
   .cie       (cie),
   .irq       (irq),
   .sec       (sec_q),
   .presc     (presc)
);

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   rtc_bcd_calendar u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // {sec,min,hour,wday,day,month,year16} preset -> expected one second later
   localparam int NVEC = 16;
   localparam logic [127:0] VEC [NVEC] = '{
      {64'h00_00_00_00_01_01_2000, 64'h01_00_00_00_01_01_2000},  // R2 plain second
      {64'h59_00_00_03_15_05_2010, 64'h00_01_00_03_15_05_2010},  // R2 minute carry
      {64'h59_59_09_01_10_07_2011, 64'h00_00_10_01_10_07_2011},  // R2 hour BCD digit
      {64'h59_59_19_05_28_02_2100, 64'h00_00_20_05_28_02_2100},  // R2 hour 19->20
      {64'h59_59_23_06_31_12_2099, 64'h00_00_00_00_01_01_2100},  // R4 century, weekday 6->0
      {64'h59_59_23_03_31_12_9999, 64'h00_00_00_04_01_01_0000},  // R4 century wraps
      {64'h59_59_23_02_28_02_2023, 64'h00_00_00_03_01_03_2023},  // R3 Feb non-leap
      {64'h59_59_23_03_28_02_2024, 64'h00_00_00_04_29_02_2024},  // R3 Feb leap 28->29
      {64'h59_59_23_04_29_02_2024, 64'h00_00_00_05_01_03_2024},  // R3 Feb leap end
      {64'h59_59_23_05_28_02_2100, 64'h00_00_00_06_29_02_2100},  // R3 year-low 00 is leap
      {64'h59_59_23_05_30_04_2024, 64'h00_00_00_06_01_05_2024},  // R3 April 30
      {64'h59_59_23_04_30_06_2012, 64'h00_00_00_05_01_07_2012},  // R3 June 30
      {64'h59_59_23_00_30_09_2024, 64'h00_00_00_01_01_10_2024},  // R3 Sept 30, month 09->10
      {64'h59_59_23_02_30_11_2025, 64'h00_00_00_03_01_12_2025},  // R3 Nov 30
      {64'h59_59_23_01_31_01_2025, 64'h00_00_00_02_01_02_2025},  // R3 Jan 31
      {64'h59_59_23_04_30_08_2012, 64'h00_00_00_05_31_08_2012}   // R3 Aug has 31
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         tick_en = 1'b1;
         @(negedge clk);
         tick_en = 1'b0;
      end
   endtask

   task automatic read_time(output logic [63:0] t);
      logic [15:0] d;
      t = '0;
      for (int a = 1; a <= 6; a++) begin
         rd(4'(a), d);
         t[64 - 8*a +: 8] = d[7:0];
      end
      rd(4'd7, d);
      t[15:0] = d;
   endtask

   task automatic load_time(input logic [63:0] t);
      wr(4'd9, 16'h0002);
      for (int a = 1; a <= 6; a++) wr(4'(a), {8'h00, t[64 - 8*a +: 8]});
      wr(4'd7, t[15:0]);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] t;
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      read_time(t);
      chk("R1 time fields", t, 64'h00_00_00_06_01_01_2000);
      rd(4'd8, d); chk("R1 ctrl1", 64'(d), 64'h00);
      rd(4'd9, d); chk("R1 ctrl2", 64'(d), 64'h00);
      rd(4'd0, d); chk("R1 subsecond", 64'(d), 64'h00);
      chk("R1 irq", 64'(irq), 64'h0);

      // R2 R3 R4 R5 table walk
      for (int v = 0; v < NVEC; v++) begin
         load_time(VEC[v][127:64]);
         wr(4'd9, 16'h0009);
         ticks(128);
         wr(4'd9, 16'h0000);
         read_time(t);
         chk($sformatf("R2/R3/R4 vector %0d", v), t, VEC[v][63:0]);
      end

      // R7 reset bit, R6 load while halted
      wr(4'd8, 16'h0000);
      wr(4'd9, 16'h0002);
      rd(4'd9, d); chk("R7 reset bit reads 0, start cleared", 64'(d), 64'h00);
      wr(4'd1, 16'h0010);
      rd(4'd1, d); chk("R6 write while halted", 64'(d), 64'h10);

      // R10 sub-second readback
      wr(4'd9, 16'h0009);
      rd(4'd9, d); chk("R7 enable+start readback", 64'(d), 64'h09);
      ticks(5);
      rd(4'd0, d); chk("R10 subsecond count", 64'(d), 64'd5);
      ticks(59);
      rd(4'd0, d); chk("R10 subsecond mid", 64'(d), 64'd64);
      wr(4'd9, 16'h000B);
      rd(4'd9, d); chk("R7 reset bit stops", 64'(d), 64'h08);
      rd(4'd0, d); chk("R7 reset bit clears prescaler", 64'(d), 64'd0);

      ticks(200);
      rd(4'd1, d); chk("R7 halted holds", 64'(d), 64'h10);
      wr(4'd9, 16'h0001);
      ticks(130);
      rd(4'd1, d); chk("R7 start without enable", 64'(d), 64'h10);

      wr(4'd9, 16'h0009);
      ticks(127);
      rd(4'd1, d); chk("R2 no step before 128th tick", 64'(d), 64'h10);
      rd(4'd8, d); chk("R8 no carry yet", 64'(d), 64'h00);
      ticks(1);
      rd(4'd1, d); chk("R2 step on 128th tick", 64'(d), 64'h11);
      rd(4'd8, d); chk("R8 carry set", 64'(d), 64'h80);
      chk("R9 irq masked", 64'(irq), 64'h0);

      wr(4'd1, 16'h0045);
      rd(4'd1, d); chk("R6 write while running ignored", 64'(d), 64'h11);

      wr(4'd8, 16'h0090);
      rd(4'd8, d); chk("R8 write 1 keeps flag", 64'(d), 64'h90);
      chk("R9 irq high", 64'(irq), 64'h1);
      wr(4'd8, 16'h0010);
      rd(4'd8, d); chk("R8 write 0 clears flag", 64'(d), 64'h10);
      chk("R9 irq drops", 64'(irq), 64'h0);
      wr(4'd8, 16'h0019);
      rd(4'd8, d); chk("R8 enables stored, alarm flag not set", 64'(d), 64'h18);
      ticks(128);
      rd(4'd8, d); chk("R8 carry again", 64'(d), 64'h98);
      chk("R9 irq on carry", 64'(irq), 64'h1);
      rd(4'd1, d); chk("R2 second again", 64'(d), 64'h12);

      wr(4'd9, 16'h00F9);
      rd(4'd9, d); chk("R7 rate stored, periodic flag not set", 64'(d), 64'h79);
      rd(4'd15, d); chk("R5 unmapped reads 0", 64'(d), 64'h0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule